// File: doc/BRIEF.md
# Control-Bit Composed Arithmetic/Logic Unit

This block computes one of eighteen arithmetic and logic functions of two operands, `op_a` and `op_b`, without any opcode decoder. Six independent control pins shape the datapath. Each operand passes through a zero stage and then an invert stage. A single core then either adds the two conditioned operands or ANDs them. A last stage may invert the core result. Constants, negations, increments, decrements, differences and OR all fall out of these compositions. For example, negation uses the two's-complement identity (-v equals the inverse of v-1), and OR uses De Morgan's law.

Alongside the result the block reports two flags: one marks an all-zero result and one copies the result's sign bit. The result and both flags are captured in a single register stage. A caller therefore sees the function of the inputs presented at a rising clock edge right after that edge.

Top module: `preset_negate_alu`

## Requirements
- R1: While `rst_n` is low, the registered outputs hold `result`=0, `is_zero`=1 and `is_neg`=0.
- R2: The outputs change only at a rising edge of `clk`. After an edge they reflect the inputs sampled at that edge (one-cycle latency).
- R3: `zero_a`=1 replaces `op_a` with 0, and `zero_b`=1 replaces `op_b` with 0. The replacement happens before any inversion.
- R4: `inv_a`=1 inverts every bit of the (possibly zeroed) A operand, and `inv_b` does the same for B. Zeroing plus inverting therefore gives all ones.
- R5: `sel_add`=1 makes the core compute the sum of the conditioned operands modulo 2^16, with the carry out discarded. `sel_add`=0 makes it compute their bitwise AND.
- R6: `inv_out`=1 inverts every bit of the core value before it becomes `result`.
- R7: `is_zero` is 1 exactly when `result` is 0.
- R8: `is_neg` equals bit 15 (the most significant bit) of `result`.
- R9: The control vector is written {zero_a,inv_a,zero_b,inv_b,sel_add,inv_out}. It yields these functions:
  - 101010 gives 0, 111111 gives 1, and 111010 gives -1.
  - 001100 gives A and 110000 gives B.
  - 001101 gives !A and 110001 gives !B.
  - 001111 gives -A and 110011 gives -B.
  - 011111 gives A+1 and 110111 gives B+1.
  - 001110 gives A-1 and 110010 gives B-1.
  - 000010 gives A+B, 010011 gives A-B and 000111 gives B-A.
  - 000000 gives A&B and 010101 gives A|B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| zero_a | input | 1 | Force operand A to zero |
| inv_a | input | 1 | Invert conditioned operand A |
| zero_b | input | 1 | Force operand B to zero |
| inv_b | input | 1 | Invert conditioned operand B |
| sel_add | input | 1 | 1: add, 0: bitwise AND |
| inv_out | input | 1 | Invert the core value |
| result | output | 16 | Registered function result |
| is_zero | output | 1 | Result equals zero |
| is_neg | output | 1 | Sign bit of result |

## Verification
Some properties are checked on every clock. The flag properties are that `is_zero` tracks an all-zero result and `is_neg` tracks the top bit. The reset values are checked as well. The bare AND and bare add paths are checked against the previous cycle's operands. The all-ones constant that the zero-then-invert ordering produces is checked too. The eighteen named functions can only be shown by the bench's scenarios. These include the two's-complement tricks for negation and the increments and decrements, and the De Morgan path for OR. Random operands and directed corner operands, such as wrap-around at the carry out and the most negative value, exercise them.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef struct packed {
        logic zero_a;
        logic inv_a;
        logic zero_b;
        logic inv_b;
        logic sel_add;
        logic inv_out;
    } alu_ctl_t;

    localparam int CTL_BITS = $bits(alu_ctl_t);

endpackage

// File: rtl/operand_prep.sv
module operand_prep #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    input  logic         force_zero,
    input  logic         invert,
    output logic [W-1:0] cond
);
    logic [W-1:0] zeroed;

    always_comb begin
        zeroed = force_zero ? '0 : raw;
        cond   = invert ? ~zeroed : zeroed;
    end

    // R3 / R4 ordering: zero then invert yields all ones
    always_comb begin
        if (force_zero && invert) begin
            a_r4_zero_then_invert: assert (&cond);
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_add,
    input  logic         inv_out,
    output logic [W-1:0] value
);
    logic [W-1:0] core;

    always_comb begin
        core  = sel_add ? (a + b) : (a & b);
        value = inv_out ? ~core : core;
    end
endmodule

// File: rtl/preset_negate_alu.sv
module preset_negate_alu #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         zero_a,
    input  logic         inv_a,
    input  logic         zero_b,
    input  logic         inv_b,
    input  logic         sel_add,
    input  logic         inv_out,
    output logic [W-1:0] result,
    output logic         is_zero,
    output logic         is_neg
);
    import alu_pkg::*;

    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        logic         zero;
        logic         neg;
        logic         primed;
    } state_t;

    alu_ctl_t     ctl;
    logic [W-1:0] a_cond;
    logic [W-1:0] b_cond;
    logic [W-1:0] value;
    state_t       st_d;
    state_t       st_q;

    assign ctl = '{zero_a: zero_a, inv_a: inv_a, zero_b: zero_b,
                   inv_b: inv_b, sel_add: sel_add, inv_out: inv_out};

    operand_prep #(.W(W)) u_prep_a (
        .raw(op_a), .force_zero(ctl.zero_a), .invert(ctl.inv_a), .cond(a_cond)
    );

    operand_prep #(.W(W)) u_prep_b (
        .raw(op_b), .force_zero(ctl.zero_b), .invert(ctl.inv_b), .cond(b_cond)
    );

    alu_core #(.W(W)) u_core (
        .a(a_cond), .b(b_cond), .sel_add(ctl.sel_add), .inv_out(ctl.inv_out),
        .value(value)
    );

    always_comb begin
        st_d        = st_q;
        st_d.res    = value;
        st_d.zero   = (value == '0);
        st_d.neg    = value[MSB];
        st_d.primed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{res: '0, zero: 1'b1, neg: 1'b0, primed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign result  = st_q.res;
    assign is_zero = st_q.zero;
    assign is_neg  = st_q.neg;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && is_zero && !is_neg));

    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        is_zero == (result == '0));

    a_r8_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        is_neg == result[MSB]);

    a_r5_and_path: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && rst_n && ctl == alu_ctl_t'(6'b000000))
        |=> (result == $past(op_a & op_b)));

    a_r5_add_path: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && rst_n && ctl == alu_ctl_t'(6'b000010))
        |=> (result == W'($past(op_a) + $past(op_b))));

    a_r9_minus_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ctl == alu_ctl_t'(6'b111010)) |=> (&result));
endmodule

// File: tb/preset_negate_alu_test.sv
module preset_negate_alu_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [5:0]   ctl = '0;
    logic [W-1:0] result;
    logic         is_zero;
    logic         is_neg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    preset_negate_alu #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .zero_a(ctl[5]), .inv_a(ctl[4]), .zero_b(ctl[3]), .inv_b(ctl[2]),
        .sel_add(ctl[1]), .inv_out(ctl[0]),
        .result(result), .is_zero(is_zero), .is_neg(is_neg)
    );

    // R9 encoding table, {zero_a,inv_a,zero_b,inv_b,sel_add,inv_out}
    function automatic logic [5:0] enc(input int idx);
        case (idx)
            0: enc = 6'b101010;  1: enc = 6'b111111;  2: enc = 6'b111010;
            3: enc = 6'b001100;  4: enc = 6'b110000;  5: enc = 6'b001101;
            6: enc = 6'b110001;  7: enc = 6'b001111;  8: enc = 6'b110011;
            9: enc = 6'b011111; 10: enc = 6'b110111; 11: enc = 6'b001110;
           12: enc = 6'b110010; 13: enc = 6'b000010; 14: enc = 6'b010011;
           15: enc = 6'b000111; 16: enc = 6'b000000; default: enc = 6'b010101;
        endcase
    endfunction

    // R9 named function value
    function automatic logic [W-1:0] named(input int idx, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        case (idx)
            0: named = '0;        1: named = W'(1);     2: named = '1;
            3: named = a;         4: named = b;         5: named = ~a;
            6: named = ~b;        7: named = -a;        8: named = -b;
            9: named = a + 1'b1; 10: named = b + 1'b1; 11: named = a - 1'b1;
           12: named = b - 1'b1; 13: named = a + b;    14: named = a - b;
           15: named = b - a;    16: named = a & b;    default: named = a | b;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (ctl=%b a=%h b=%h)",
                     req, act, exp, ctl, op_a, op_b);
        end
    endtask

    // R2: drive at negedge, result visible after the next posedge
    task automatic apply(input logic [5:0] c, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] exp,
                         input string req);
        @(negedge clk);
        ctl = c; op_a = a; op_b = b;
        @(negedge clk);
        check(req, result, exp);
        check("R7", W'(is_zero), W'(exp == '0));
        check("R8", W'(is_neg), W'(exp[W-1]));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a;
        logic [W-1:0] b;
        void'($urandom(32'd2024));
        ctl = 6'b000010; op_a = 16'h1234; op_b = 16'h1111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", result, '0);
        check("R1", W'(is_zero), W'(1));
        check("R1", W'(is_neg), W'(0));
        rst_n = 1'b1;

        // R2: no change before the edge
        @(negedge clk);
        ctl = 6'b000010; op_a = 16'h0003; op_b = 16'h0004;
        #2;
        check("R2", result, 16'h2345);
        @(negedge clk);
        check("R2", result, 16'h0007);

        // R3 / R4 ordering
        apply(6'b100000, 16'hABCD, 16'hFFFF, 16'h0000, "R3");
        apply(6'b110000, 16'hABCD, 16'h5A5A, 16'h5A5A, "R4");
        apply(6'b001100, 16'hABCD, 16'h1357, 16'hABCD, "R4");
        // R5 add wraps, AND path
        apply(6'b000010, 16'hFFFF, 16'h0001, 16'h0000, "R5");
        apply(6'b000010, 16'h7FFF, 16'h0001, 16'h8000, "R5");
        apply(6'b000000, 16'hF0F0, 16'h3C3C, 16'h3030, "R5");
        // R6 output inversion
        apply(6'b000001, 16'hF0F0, 16'h3C3C, 16'hCFCF, "R6");

        // R9 every encoding: directed corners then random operands
        for (int i = 0; i < 18; i++) begin
            apply(enc(i), 16'h8000, 16'h0001, named(i, 16'h8000, 16'h0001), "R9");
            apply(enc(i), 16'h0000, 16'hFFFF, named(i, 16'h0000, 16'hFFFF), "R9");
            for (int k = 0; k < 30; k++) begin
                a = W'($urandom);
                b = W'($urandom);
                apply(enc(i), a, b, named(i, a, b), "R9");
            end
        end

        // R1 again: reset mid-run
        @(negedge clk);
        ctl = 6'b111111; rst_n = 1'b0;
        @(negedge clk);
        check("R1", result, '0);
        check("R1", W'(is_zero), W'(1));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule